// File: doc/BRIEF.md
# One-Time Memory Commit Sequencer

This block commits the configuration registers of a motor controller into its one-time-programmable store. A one-cycle start request launches a fixed series of six register writes. Four unlock-key writes and a mode write come first. A timed pause follows, and then a final commit word. Every write leaves the block as an address and a 16-bit data word on a valid/ready port, which normally feeds a serial-bus master. The block never writes configuration values of its own: software must load them into the registers before it asks for a commit.

The sequence runs only while the device enable input is high. If enable drops before the commit word is accepted, the sequence aborts, error pulses and the commit is never issued. After a successful commit a sticky burned flag refuses any later start. That flag clears only through a reset-value parameter, which stands for unprogrammed silicon. The pause length is given in microseconds and converted to clock cycles, rounded up, so the pause is never shorter than requested.

Top module: `otp_burn_seq`

## Requirements
- R1: During and right after reset: busy_o, done_o, error_o and wr_valid_o are low, and burned_o equals the START_BURNED parameter (default 0).
- R2: A start_i pulse while idle, with enable_i high and burned_o low, raises busy_o from the next cycle. The first write is then presented on the port.
- R3: Six writes are issued in this order, as {address, data}: {0x2D,0x1213}, {0x2D,0x1415}, {0x2D,0x1617}, {0x2D,0x1819}, {0x39,0x0002}, {0x2D,0x0EDD}. The address is wr_addr_o, zero-extended from 8 bits, and the data is wr_data_o.
- R4: A write counts as accepted on a rising edge where wr_valid_o and wr_ready_i are both high. Until then, with enable_i high, wr_valid_o stays high and wr_addr_o and wr_data_o stay unchanged. Only one write is outstanding at a time.
- R5: After the fifth write is accepted, wr_valid_o stays low for exactly ceil(CLK_HZ*WAIT_US/1e6) cycles while busy_o stays high. Then the final write is presented.
- R6: In the cycle after the final write is accepted, done_o is high for exactly one cycle, burned_o is high and busy_o is low.
- R7: A start_i pulse while idle with enable_i low issues no write. It raises error_o for exactly one cycle, starting on the next cycle.
- R8: A start_i pulse while burned_o is high issues no write. It raises error_o for one cycle.
- R9: If enable_i goes low while busy, wr_valid_o drops in the same cycle. On the next cycle error_o pulses, busy_o falls and burned_o is left unchanged. The rest of the sequence, including the commit word, is never issued.
- R10: A start_i pulse while busy has no effect: no extra write is issued and the sequence continues.
- R11: burned_o, once high, stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to run the commit sequence |
| enable_i | input | 1 | Device enable; must stay high for the whole sequence |
| wr_valid_o | output | 1 | Write request valid |
| wr_addr_o | output | ADDR_W | Register address of the current write |
| wr_data_o | output | DATA_W | Data word of the current write |
| wr_ready_i | input | 1 | Downstream accepts the current write |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: commit word accepted |
| error_o | output | 1 | One-cycle pulse: start refused or sequence aborted |
| burned_o | output | 1 | Sticky flag: memory already committed |

## Verification
A step index that is off by one shows up on the write port at the next accepted write, as a key word out of order or a missing or extra write. The scoreboard catches it at that handshake. A wrong pause counter shows up when the sixth write appears, as a gap one or more cycles away from the computed count. A state that misses an abort or a refusal shows up within one cycle, as an error pulse that is missing or late, or as a write valid that stays high after enable falls.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

   localparam int unsigned NUM_WRITES = 6;
   localparam int unsigned PAUSE_IDX  = 4;
   localparam int unsigned STEP_W     = $clog2(NUM_WRITES);

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WRITE = 2'd1,
      ST_PAUSE = 2'd2
   } burn_state_e;

   // Register address for each step of the commit series.
   function automatic logic [7:0] step_addr(input logic [STEP_W-1:0] idx);
      logic [7:0] a;
      case (idx)
         STEP_W'(PAUSE_IDX): a = 8'h39;
         default:            a = 8'h2D;
      endcase
      return a;
   endfunction

   // Data word for each step: four ascending key pairs, mode word, commit word.
   function automatic logic [15:0] step_data(input logic [STEP_W-1:0] idx);
      logic [15:0] d;
      if (idx < STEP_W'(PAUSE_IDX)) begin
         d[15:8] = 8'h12 + {4'd0, idx, 1'b0};
         d[7:0]  = 8'h13 + {4'd0, idx, 1'b0};
      end else if (idx == STEP_W'(PAUSE_IDX)) begin
         d = 16'h0002;
      end else begin
         d = 16'h0EDD;
      end
      return d;
   endfunction

endpackage

// File: rtl/otp_burn_keyrom.sv
module otp_burn_keyrom
   import otp_burn_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic [STEP_W-1:0] step_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("otp_burn_keyrom: ADDR_W must be at least 8");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("otp_burn_keyrom: DATA_W must be at least 16");
   end

   localparam int unsigned APAD = (ADDR_W > 8)  ? ADDR_W - 8  : 0;
   localparam int unsigned DPAD = (DATA_W > 16) ? DATA_W - 16 : 0;

   logic [7:0]  raw_addr;
   logic [15:0] raw_data;

   always_comb begin
      raw_addr = step_addr(step_i);
      raw_data = step_data(step_i);
   end

   if (APAD == 0) begin : g_addr_exact
      assign addr_o = raw_addr;
   end else begin : g_addr_pad
      assign addr_o = {{APAD{1'b0}}, raw_addr};
   end

   if (DPAD == 0) begin : g_data_exact
      assign data_o = raw_data;
   end else begin : g_data_pad
      assign data_o = {{DPAD{1'b0}}, raw_data};
   end

endmodule

// File: rtl/otp_burn_waittimer.sv
module otp_burn_waittimer #(
   parameter longint unsigned WAIT_CYC = 64'd2_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("otp_burn_waittimer: WAIT_CYC must be at least 1");
   end

   if (WAIT_CYC == 1) begin : g_single
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign expired_o      = run_i;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(WAIT_CYC);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!run_i || cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign expired_o = run_i && (cnt_q == LAST);
   end

endmodule

// File: rtl/otp_burn_ctrl.sv
module otp_burn_ctrl
   import otp_burn_pkg::*;
#(
   parameter bit START_BURNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              enable_i,
   input  logic              wr_ready_i,
   input  logic              expired_i,
   output logic              wr_valid_o,
   output logic [STEP_W-1:0] step_o,
   output logic              pause_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              error_o,
   output logic              burned_o
);

   localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(NUM_WRITES - 1);
   localparam logic [STEP_W-1:0] PAUSE_STEP = STEP_W'(PAUSE_IDX);

   burn_state_e       state_q;
   logic [STEP_W-1:0] step_q;
   logic              done_q, err_q, burned_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         step_q   <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         burned_q <= START_BURNED;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (enable_i && !burned_q) begin
                     state_q <= ST_WRITE;
                     step_q  <= '0;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_WRITE: begin
               if (!enable_i) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (wr_ready_i) begin
                  if (step_q == LAST_STEP) begin
                     state_q  <= ST_IDLE;
                     done_q   <= 1'b1;
                     burned_q <= 1'b1;
                  end else begin
                     step_q <= step_q + 1'b1;
                     if (step_q == PAUSE_STEP) begin
                        state_q <= ST_PAUSE;
                     end
                  end
               end
            end
            ST_PAUSE: begin
               if (!enable_i) begin
                  err_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (expired_i) begin
                  state_q <= ST_WRITE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_valid_o = (state_q == ST_WRITE) && enable_i;
   assign pause_o    = (state_q == ST_PAUSE);
   assign busy_o     = (state_q != ST_IDLE);
   assign step_o     = step_q;
   assign done_o     = done_q;
   assign error_o    = err_q;
   assign burned_o   = burned_q;

endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
   import otp_burn_pkg::*;
#(
   parameter int unsigned     ADDR_W       = 8,
   parameter int unsigned     DATA_W       = 16,
   parameter longint unsigned CLK_HZ       = 64'd200_000_000,
   parameter int unsigned     WAIT_US      = 10_000,
   parameter bit              START_BURNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              enable_i,
   output logic              wr_valid_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   input  logic              wr_ready_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              error_o,
   output logic              burned_o
);

   localparam longint unsigned WAIT_CYC =
      (CLK_HZ * longint'(WAIT_US) + 64'd999_999) / 64'd1_000_000;

   if (CLK_HZ == 0 || WAIT_US == 0) begin : g_bad_time
      $error("otp_burn_seq: CLK_HZ and WAIT_US must be non-zero");
   end

   logic [STEP_W-1:0] step;
   logic              pause, expired;

   otp_burn_ctrl #(
      .START_BURNED (START_BURNED)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .enable_i   (enable_i),
      .wr_ready_i (wr_ready_i),
      .expired_i  (expired),
      .wr_valid_o (wr_valid_o),
      .step_o     (step),
      .pause_o    (pause),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .error_o    (error_o),
      .burned_o   (burned_o)
   );

   otp_burn_waittimer #(
      .WAIT_CYC (WAIT_CYC)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (pause),
      .expired_o (expired)
   );

   otp_burn_keyrom #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_rom (
      .step_i (step),
      .addr_o (wr_addr_o),
      .data_o (wr_data_o)
   );

endmodule

// File: rtl/otp_burn_chk.sv
module otp_burn_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              enable_i,
   input logic              wr_valid_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              wr_ready_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              error_o,
   input logic              burned_o
);

   // R4: a stalled write keeps its content while enable holds
   p_hold_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && !wr_ready_i) |=>
         (!enable_i || (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))));

   // R6: completion implies the flag is set and the block is idle
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (burned_o && !busy_o && !error_o));

   // R7: refused start on disabled device
   p_refuse_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && !enable_i) |=> (error_o && !busy_o));

   // R8: refused start after commit
   p_refuse_burned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && burned_o) |=> (error_o && !busy_o && !wr_valid_o));

   // R9: losing enable mid-sequence aborts with an error
   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !enable_i) |=> (error_o && !busy_o && !done_o));

   // R11: the burned flag is sticky
   p_burned_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      burned_o |=> burned_o);

endmodule

bind otp_burn_seq otp_burn_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/tb_otp_burn_seq.sv
`timescale 1ns/1ps
module tb_otp_burn_seq;

   localparam longint unsigned TB_HZ = 64'd200_000_000;
   localparam int unsigned     TB_US = 20;
   localparam int EXP_GAP = int'((TB_HZ * longint'(TB_US) + 64'd999_999) / 64'd1_000_000);

   logic        clk = 1'b0;
   logic        rst_n, start_i, enable_i, wr_ready_i;
   logic        wr_valid_o, busy_o, done_o, error_o, burned_o;
   logic [7:0]  wr_addr_o;
   logic [15:0] wr_data_o;

   otp_burn_seq #(.CLK_HZ(TB_HZ), .WAIT_US(TB_US)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .enable_i(enable_i),
      .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_ready_i(wr_ready_i), .busy_o(busy_o), .done_o(done_o),
      .error_o(error_o), .burned_o(burned_o)
   );

   always #2.5 clk = ~clk;

   int          n_chk = 0, n_fail = 0;
   int          hs_count = 0;
   logic [23:0] exp_q[$];
   bit          gap_on = 0, measuring = 0, gap_checked = 0;
   int          gap = 0;
   bit          rdy_rand = 0;
   logic [7:0]  lfsr = 8'hA5;
   bit          held_prev = 0;
   logic [7:0]  prev_addr;
   logic [15:0] prev_data;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   // Expected write list, built from R3
   function automatic logic [23:0] exp_item(input int i);
      logic [7:0] hi, lo;
      if (i < 4) begin
         hi = 8'h12 + 8'(2 * i);
         lo = 8'h13 + 8'(2 * i);
         return {8'h2D, hi, lo};
      end else if (i == 4) begin
         return {8'h39, 16'h0002};
      end
      return {8'h2D, 16'h0EDD};
   endfunction

   task automatic push_seq(input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(exp_item(i));
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // Ready driver
   always @(posedge clk) begin
      #1;
      if (rdy_rand) begin
         lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         wr_ready_i <= lfsr[0] | lfsr[3];
      end else begin
         wr_ready_i <= 1'b1;
      end
   end

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (held_prev && enable_i)
            check(wr_valid_o && wr_addr_o == prev_addr && wr_data_o == prev_data,
                  "R4", "stalled write changed", {wr_valid_o, wr_addr_o, wr_data_o},
                  {1'b1, prev_addr, prev_data});
         if (measuring) begin
            if (!wr_valid_o) gap++;
            else begin
               check(gap == EXP_GAP, "R5", "pause length", gap, EXP_GAP);
               measuring   = 0;
               gap_checked = 1;
            end
         end
         if (wr_valid_o && wr_ready_i) begin
            if (exp_q.size() == 0) begin
               check(0, "R10", "unexpected write", {wr_addr_o, wr_data_o}, 0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               check({wr_addr_o, wr_data_o} == e, "R3", "write content",
                     {wr_addr_o, wr_data_o}, e);
            end
            hs_count++;
            if (gap_on && hs_count == 5) begin
               measuring = 1;
               gap       = 0;
            end
         end
         held_prev = wr_valid_o && !wr_ready_i;
         prev_addr = wr_addr_o;
         prev_data = wr_data_o;
      end
   end

   // Watchdog
   initial begin
      repeat (150_000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; start_i = 0; enable_i = 0; wr_ready_i = 0;
      repeat (4) tick();
      @(negedge clk);
      check({busy_o, wr_valid_o, done_o, error_o, burned_o} == 5'b0, "R1",
            "reset outputs", {busy_o, wr_valid_o, done_o, error_o, burned_o}, 0);
      tick(); rst_n = 1;
      tick();
      @(negedge clk);
      check({busy_o, wr_valid_o, done_o, error_o, burned_o} == 5'b0, "R1",
            "after reset", {busy_o, wr_valid_o, done_o, error_o, burned_o}, 0);

      // R7: start with enable low
      tick(); start_i = 1;
      tick(); start_i = 0;
      @(negedge clk);
      check(error_o == 1, "R7", "error pulse", error_o, 1);
      check(!wr_valid_o && !busy_o, "R7", "no write", {wr_valid_o, busy_o}, 0);
      tick();
      @(negedge clk);
      check(error_o == 0, "R7", "error one cycle", error_o, 0);

      // R9: abort during the write phase
      enable_i = 1; hs_count = 0; push_seq(2); rdy_rand = 1;
      tick(); start_i = 1;
      tick(); start_i = 0;
      @(negedge clk);
      check(busy_o == 1, "R2", "busy after start", busy_o, 1);
      check(wr_valid_o && wr_addr_o == 8'h2D && wr_data_o == 16'h1213, "R2",
            "first write", {wr_valid_o, wr_addr_o, wr_data_o}, {1'b1, 8'h2D, 16'h1213});
      while (hs_count < 2) tick();
      enable_i = 0;
      #0.5;
      check(wr_valid_o == 0, "R9", "valid drops with enable", wr_valid_o, 0);
      tick();
      @(negedge clk);
      check(error_o && !busy_o && !burned_o, "R9", "abort in write",
            {error_o, busy_o, burned_o}, 3'b100);
      check(exp_q.size() == 0, "R9", "writes after abort", exp_q.size(), 0);

      // R9: abort during the pause, ready always high
      rdy_rand = 0; enable_i = 1; hs_count = 0; push_seq(5);
      tick(); start_i = 1;
      tick(); start_i = 0;
      while (hs_count < 5) tick();
      repeat (100) tick();
      @(negedge clk);
      check(busy_o && !wr_valid_o, "R5", "pausing", {busy_o, wr_valid_o}, 2'b10);
      tick(); enable_i = 0;
      tick();
      @(negedge clk);
      check(error_o && !busy_o && !burned_o, "R9", "abort in pause",
            {error_o, busy_o, burned_o}, 3'b100);
      enable_i = 1;
      repeat (EXP_GAP + 20) tick();
      check(hs_count == 5 && !burned_o, "R9", "no commit after abort",
            hs_count, 5);

      // Full run with random ready, extra start while busy
      rdy_rand = 1; hs_count = 0; push_seq(6); gap_on = 1;
      tick(); start_i = 1;
      tick(); start_i = 0;
      while (hs_count < 1) tick();
      start_i = 1;
      tick(); start_i = 0;
      @(negedge clk);
      check(busy_o == 1, "R10", "start while busy ignored", busy_o, 1);
      while (hs_count < 6) tick();
      @(negedge clk);
      check(done_o && burned_o && !busy_o, "R6", "completion",
            {done_o, burned_o, busy_o}, 3'b110);
      tick();
      @(negedge clk);
      check(!done_o && burned_o, "R6", "done one cycle", {done_o, burned_o}, 2'b01);
      check(exp_q.size() == 0, "R3", "all writes seen", exp_q.size(), 0);
      check(gap_checked, "R5", "pause measured", gap_checked, 1);
      gap_on = 0;

      // R8: second start refused
      tick(); start_i = 1;
      tick(); start_i = 0;
      @(negedge clk);
      check(error_o && !busy_o && !wr_valid_o, "R8", "second burn refused",
            {error_o, busy_o, wr_valid_o}, 3'b100);
      repeat (10) tick();
      check(hs_count == 6 && burned_o, "R11", "flag held, no writes",
            {hs_count[7:0], burned_o}, {8'd6, 1'b1});

      summary();
      $finish;
   end

endmodule